// File: doc/BRIEF.md
# Prescaled Reloadable Timer Pair

The block holds two independent down-counting timers behind a small register port. One timer, the real-time clock (RTC), has an 8-bit prescaler. The other, the general-purpose timer (GPT), has a 16-bit prescaler. Each timer has a 32-bit counter and a 32-bit reload value. While a timer runs, its prescaler counts down from the programmed scaler value. Each time the prescaler passes zero, the counter takes one step. A step on a counter that already holds zero is an underflow. An underflow gives one interrupt pulse, and then the timer either reloads and keeps running or stops.

Software writes registers with `wr_en`, `addr` and `wdata`. A write takes effect at the clock edge that samples `wr_en`. Reads are combinational: `rdata` always shows the register that `addr` selects, computed from the state left by the last edge. One control register drives both timers. Each control write sets reload-enable and run for both timers, and can also load a counter or restart a prescaler. The port has no data stream, so it carries no valid/ready handshake. Every write is accepted in the cycle it is presented.

Top module: `tmr_pair`

## Requirements
- R1: After reset, both counters and both reload values are 0xFFFFFFFF, both scalers and prescalers are 0, both timers are stopped, and `rtc_irq`, `gpt_irq` and `par_err` are low.
- R2: While a timer runs, its counter decreases by one once every (scaler + 1) clock cycles. The step happens on the cycle in which the prescaler holds 0.
- R3: A step taken while the counter is 0 is an underflow. It drives that timer's interrupt high for exactly the one cycle after the step's edge.
- R4: On underflow with reload-enable set, the counter takes the reload value and the timer keeps running. With reload-enable clear, the counter stays at 0, the timer stops, and no further interrupts occur.
- R5: A write to a counter address changes only the reload value. A read of that address returns the live counter.
- R6: Control register fields: the RTC uses bits [11:8] and the GPT uses bits [3:0]. Within each 4-bit field, bit 0 is reload-enable, bit 1 loads the counter from the reload value, bit 2 is run enable, and bit 3 restarts the prescaler from the scaler value.
- R7: Address map: 0 is the RTC counter/reload, 1 the RTC scaler, 2 the GPT counter/reload, 3 the GPT scaler, and 4 the control register. The control register and addresses 5 to 7 read as 0. Writes to addresses 5 to 7 have no effect.
- R8: A read of a scaler address returns the prescaler's remaining count, zero-extended. Writes keep only the low 8 bits (RTC) or the low 16 bits (GPT) of the data.
- R9: `par_err` is high for one cycle after any of these writes: a scaler write with bits set above that scaler's width, or a control write with bits set outside [11:8] and [3:0].
- R10: Setting run enable on a stopped timer restarts its prescaler from the scaler value. Setting it on a running timer leaves the prescaler alone. Clearing it stops the timer and holds its counter.
- R11: In a cycle that writes the control register, neither timer takes a prescaler or counter step, so no interrupt can follow that edge.
- R12: A scaler write does not change the live prescaler count. The new value is used at the next period boundary or restart.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| rtc_irq | output | 1 | RTC underflow pulse |
| gpt_irq | output | 1 | GPT underflow pulse |
| par_err | output | 1 | Out-of-range write pulse |

## Verification
Any drift in a prescaler shows on the scaler read address in the very next cycle, because that address returns the live count. A wrong counter step shows one cycle after the step, at the counter address. A lost or spurious reload shows as an interrupt pulse in the wrong cycle, and the counter read then disagrees for a whole period. A control write that fails to suppress counting, or that restarts a running prescaler, moves every later tick. The mismatch appears within one prescaler period and stays in both `rdata` and the interrupt timing.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_RTC_CNT = 3'd0;
  localparam logic [ADDR_W-1:0] A_RTC_SCL = 3'd1;
  localparam logic [ADDR_W-1:0] A_GPT_CNT = 3'd2;
  localparam logic [ADDR_W-1:0] A_GPT_SCL = 3'd3;
  localparam logic [ADDR_W-1:0] A_CTRL    = 3'd4;

  // lowest bit of each timer's 4-bit control field
  localparam int RTC_FLD_LSB = 8;
  localparam int GPT_FLD_LSB = 0;
  localparam int FLD_W       = 4;

  // field layout, LSB first: reload-enable, load, run, prescaler restart
  typedef struct packed {
    logic sload;
    logic en;
    logic load;
    logic rel;
  } tmr_ctl_t;
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int SCW = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           scl_wr,
  input  logic [SCW-1:0] scl_val,
  input  logic           restart,
  input  logic           step,
  output logic           tick,
  output logic [SCW-1:0] remain
);
  logic [SCW-1:0] scl_q;
  logic [SCW-1:0] pre_q;

  assign tick   = step && (pre_q == '0);
  assign remain = pre_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= '0;
      pre_q <= '0;
    end else begin
      if (scl_wr) scl_q <= scl_val;
      if (restart)    pre_q <= scl_q;
      else if (step)  pre_q <= (pre_q == '0) ? scl_q : pre_q - 1'b1;
    end
  end
endmodule

// File: rtl/tmr_downcount.sv
module tmr_downcount #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rld_wr,
  input  logic [CNT_W-1:0] rld_val,
  input  logic             load,
  input  logic             tick,
  input  logic             auto_rel,
  output logic [CNT_W-1:0] count,
  output logic             uflow
);
  logic [CNT_W-1:0] rld_q;
  logic [CNT_W-1:0] cnt_q;

  assign uflow = tick && (cnt_q == '0);
  assign count = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rld_q <= '1;
      cnt_q <= '1;
    end else begin
      if (rld_wr) rld_q <= rld_val;
      if (load) begin
        cnt_q <= rld_q;
      end else if (tick) begin
        if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
        else if (auto_rel) cnt_q <= rld_q;
      end
    end
  end
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int SCW   = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rld_wr,
  input  logic             scl_wr,
  input  logic [CNT_W-1:0] rld_val,
  input  logic [SCW-1:0]   scl_val,
  input  logic             ctl_wr,
  input  tmr_ctl_t         ctl,
  output logic [CNT_W-1:0] count,
  output logic [SCW-1:0]   remain,
  output logic             irq
);
  logic run_q, rel_q, irq_q;
  logic step, tick, restart, uflow;

  // a control write replaces this cycle's counting step
  assign step    = run_q && !ctl_wr;
  assign restart = ctl_wr && (ctl.sload || (ctl.en && !run_q));

  tmr_prescaler #(.SCW(SCW)) u_pre (
    .clk     (clk),
    .rst_n   (rst_n),
    .scl_wr  (scl_wr),
    .scl_val (scl_val),
    .restart (restart),
    .step    (step),
    .tick    (tick),
    .remain  (remain)
  );

  tmr_downcount #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .rld_wr   (rld_wr),
    .rld_val  (rld_val),
    .load     (ctl_wr && ctl.load),
    .tick     (tick),
    .auto_rel (rel_q),
    .count    (count),
    .uflow    (uflow)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      rel_q <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      irq_q <= uflow;
      if (ctl_wr) begin
        run_q <= ctl.en;
        rel_q <= ctl.rel;
      end else if (uflow && !rel_q) begin
        run_q <= 1'b0;
      end
    end
  end

  assign irq = irq_q;
endmodule

// File: rtl/tmr_regif.sv
module tmr_regif
  import tmr_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int RTC_SCW = 8,
  parameter int GPT_SCW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              rtc_rld_wr,
  output logic              rtc_scl_wr,
  output logic              gpt_rld_wr,
  output logic              gpt_scl_wr,
  output logic              ctl_wr,
  output tmr_ctl_t          rtc_ctl,
  output tmr_ctl_t          gpt_ctl,
  output logic              par_err
);
  localparam logic [DATA_W-1:0] NIB      = {{(DATA_W-FLD_W){1'b0}}, {FLD_W{1'b1}}};
  localparam logic [DATA_W-1:0] CTL_KEEP = (NIB << RTC_FLD_LSB) | (NIB << GPT_FLD_LSB);

  logic bad_wr, par_q;

  assign rtc_rld_wr = wr_en && (addr == A_RTC_CNT);
  assign rtc_scl_wr = wr_en && (addr == A_RTC_SCL);
  assign gpt_rld_wr = wr_en && (addr == A_GPT_CNT);
  assign gpt_scl_wr = wr_en && (addr == A_GPT_SCL);
  assign ctl_wr     = wr_en && (addr == A_CTRL);

  assign rtc_ctl = tmr_ctl_t'(wdata[RTC_FLD_LSB +: FLD_W]);
  assign gpt_ctl = tmr_ctl_t'(wdata[GPT_FLD_LSB +: FLD_W]);

  always_comb begin
    bad_wr = 1'b0;
    if (rtc_scl_wr && (wdata[DATA_W-1:RTC_SCW] != '0)) bad_wr = 1'b1;
    if (gpt_scl_wr && (wdata[DATA_W-1:GPT_SCW] != '0)) bad_wr = 1'b1;
    if (ctl_wr && ((wdata & ~CTL_KEEP) != '0))         bad_wr = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) par_q <= 1'b0;
    else        par_q <= bad_wr;
  end

  assign par_err = par_q;
endmodule

// File: rtl/tmr_pair.sv
module tmr_pair
  import tmr_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int RTC_SCW = 8,
  parameter int GPT_SCW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [2:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              rtc_irq,
  output logic              gpt_irq,
  output logic              par_err
);
  logic rtc_rld_wr, rtc_scl_wr, gpt_rld_wr, gpt_scl_wr, ctl_wr;
  tmr_ctl_t rtc_ctl, gpt_ctl;
  logic [DATA_W-1:0]  rtc_cnt, gpt_cnt;
  logic [RTC_SCW-1:0] rtc_rem;
  logic [GPT_SCW-1:0] gpt_rem;

  tmr_regif #(.DATA_W(DATA_W), .RTC_SCW(RTC_SCW), .GPT_SCW(GPT_SCW)) u_regif (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .addr       (addr),
    .wdata      (wdata),
    .rtc_rld_wr (rtc_rld_wr),
    .rtc_scl_wr (rtc_scl_wr),
    .gpt_rld_wr (gpt_rld_wr),
    .gpt_scl_wr (gpt_scl_wr),
    .ctl_wr     (ctl_wr),
    .rtc_ctl    (rtc_ctl),
    .gpt_ctl    (gpt_ctl),
    .par_err    (par_err)
  );

  tmr_channel #(.CNT_W(DATA_W), .SCW(RTC_SCW)) u_rtc (
    .clk     (clk),
    .rst_n   (rst_n),
    .rld_wr  (rtc_rld_wr),
    .scl_wr  (rtc_scl_wr),
    .rld_val (wdata),
    .scl_val (wdata[RTC_SCW-1:0]),
    .ctl_wr  (ctl_wr),
    .ctl     (rtc_ctl),
    .count   (rtc_cnt),
    .remain  (rtc_rem),
    .irq     (rtc_irq)
  );

  tmr_channel #(.CNT_W(DATA_W), .SCW(GPT_SCW)) u_gpt (
    .clk     (clk),
    .rst_n   (rst_n),
    .rld_wr  (gpt_rld_wr),
    .scl_wr  (gpt_scl_wr),
    .rld_val (wdata),
    .scl_val (wdata[GPT_SCW-1:0]),
    .ctl_wr  (ctl_wr),
    .ctl     (gpt_ctl),
    .count   (gpt_cnt),
    .remain  (gpt_rem),
    .irq     (gpt_irq)
  );

  always_comb begin
    unique case (addr)
      A_RTC_CNT: rdata = rtc_cnt;
      A_RTC_SCL: rdata = {{(DATA_W-RTC_SCW){1'b0}}, rtc_rem};
      A_GPT_CNT: rdata = gpt_cnt;
      A_GPT_SCL: rdata = {{(DATA_W-GPT_SCW){1'b0}}, gpt_rem};
      default:   rdata = '0;
    endcase
  end
endmodule

// File: rtl/tmr_pair_chk.sv
module tmr_pair_chk
  import tmr_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int RTC_SCW = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [2:0]        addr,
  input logic [DATA_W-1:0] rdata,
  input logic              rtc_irq,
  input logic              gpt_irq,
  input logic              par_err
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |=> (!rtc_irq && !gpt_irq && !par_err));

  // R11
  ctl_blocks_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_en && (addr == A_CTRL)) |-> (!rtc_irq && !gpt_irq));

  // R9
  par_after_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    par_err |-> $past(wr_en));

  // R2
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(addr) == A_RTC_CNT) && (addr == A_RTC_CNT) && !$past(wr_en))
      |-> ((rdata == $past(rdata)) || (rdata == $past(rdata) - 1) || rtc_irq));

  // R8
  scl_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == A_RTC_SCL) |-> (rdata[DATA_W-1:RTC_SCW] == '0));
endmodule

bind tmr_pair tmr_pair_chk #(.DATA_W(DATA_W), .RTC_SCW(RTC_SCW)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .wr_en   (wr_en),
  .addr    (addr),
  .rdata   (rdata),
  .rtc_irq (rtc_irq),
  .gpt_irq (gpt_irq),
  .par_err (par_err)
);

// File: tb/tmr_pair_tb_top.sv
module tmr_pair_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  addr = 3'd0;
  logic [31:0] wdata = 32'd0;
  logic [31:0] rdata;
  logic        rtc_irq, gpt_irq, par_err;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  tmr_pair dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .rtc_irq(rtc_irq), .gpt_irq(gpt_irq), .par_err(par_err)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // ---------------- behavioural reference ----------------
  logic [31:0] m_cnt [2];
  logic [31:0] m_rld [2];
  logic [31:0] m_scl [2];
  logic [31:0] m_pre [2];
  bit          m_run [2];
  bit          m_rel [2];
  bit          m_irq [2];
  bit          m_par;
  logic [31:0] o_rld [2];
  logic [31:0] o_scl [2];
  logic [3:0]  fb;
  bit          sw;
  logic [2:0]  sa;
  logic [31:0] sd;

  function automatic logic [31:0] mread(input logic [2:0] a);
    case (a)
      3'd0: return m_cnt[0];
      3'd1: return m_pre[0];
      3'd2: return m_cnt[1];
      3'd3: return m_pre[1];
      default: return 32'd0;
    endcase
  endfunction

  always @(posedge clk) begin
    sw = wr_en; sa = addr; sd = wdata;
    if (!rst_n) begin
      for (int t = 0; t < 2; t++) begin
        m_cnt[t] = 32'hFFFF_FFFF; m_rld[t] = 32'hFFFF_FFFF;
        m_scl[t] = 0; m_pre[t] = 0; m_run[t] = 0; m_rel[t] = 0; m_irq[t] = 0;
      end
      m_par = 0;
    end else begin
      for (int t = 0; t < 2; t++) begin
        o_rld[t] = m_rld[t]; o_scl[t] = m_scl[t]; m_irq[t] = 0;
      end
      m_par = sw && ((sa == 3'd1 && sd[31:8] != 0) || (sa == 3'd3 && sd[31:16] != 0) ||
                     (sa == 3'd4 && (sd & ~32'h0F0F) != 0));
      if (sw && sa == 3'd4) begin
        for (int t = 0; t < 2; t++) begin
          fb = (t == 0) ? sd[11:8] : sd[3:0];
          m_rel[t] = fb[0];
          if (fb[1]) m_cnt[t] = o_rld[t];
          if (fb[3] || (fb[2] && !m_run[t])) m_pre[t] = o_scl[t];
          m_run[t] = fb[2];
        end
      end else begin
        for (int t = 0; t < 2; t++) begin
          if (m_run[t]) begin
            if (m_pre[t] == 0) begin
              m_pre[t] = o_scl[t];
              if (m_cnt[t] == 0) begin
                m_irq[t] = 1;
                if (m_rel[t]) m_cnt[t] = o_rld[t];
                else          m_run[t] = 0;
              end else begin
                m_cnt[t] = m_cnt[t] - 1;
              end
            end else begin
              m_pre[t] = m_pre[t] - 1;
            end
          end
        end
      end
      if (sw) begin
        case (sa)
          3'd0: m_rld[0] = sd;
          3'd1: m_scl[0] = sd & 32'hFF;
          3'd2: m_rld[1] = sd;
          3'd3: m_scl[1] = sd & 32'hFFFF;
          default: ;
        endcase
      end
    end
    #3;
    if (!done) begin
      if (addr == 3'd0 || addr == 3'd2)      chk("R2 counter readback", rdata, mread(addr));
      else if (addr == 3'd1 || addr == 3'd3) chk("R8 scaler readback", rdata, mread(addr));
      else                                   chk("R7 control/unmapped readback", rdata, mread(addr));
      chk("R3 rtc_irq", {31'd0, rtc_irq}, {31'd0, m_irq[0]});
      chk("R3 gpt_irq", {31'd0, gpt_irq}, {31'd0, m_irq[1]});
      chk("R9 par_err", {31'd0, par_err}, {31'd0, m_par});
    end
  end

  // ---------------- stimulus ----------------
  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic setaddr(input logic [2:0] a);
    addr = a;
    #1;
  endtask

  task automatic summary;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    int n;
    logic [31:0] hold;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    setaddr(3'd0); chk("R1 rtc counter reset", rdata, 32'hFFFF_FFFF);
    setaddr(3'd3); chk("R1 gpt scaler reset", rdata, 32'd0);
    chk("R1 irq quiet", {30'd0, rtc_irq, gpt_irq}, 32'd0);

    // reload write leaves counter alone
    wr(3'd0, 32'd5);
    setaddr(3'd0); chk("R5 counter unchanged by reload write", rdata, 32'hFFFF_FFFF);

    // over-wide RTC scaler
    wr(3'd1, 32'h1FF);
    chk("R9 par_err on wide scaler", {31'd0, par_err}, 32'd1);
    setaddr(3'd1); chk("R12 live count untouched by scaler write", rdata, 32'd0);

    // unmapped address
    wr(3'd5, 32'hFFFF_FFFF);
    setaddr(3'd5); chk("R7 unmapped reads zero", rdata, 32'd0);
    chk("R7 unmapped write no par_err", {31'd0, par_err}, 32'd0);
    setaddr(3'd1); chk("R7 unmapped write no effect", rdata, 32'd0);

    // RTC one-shot: load + run, scaler 0xFF
    wr(3'd4, 32'h0000_0600);
    setaddr(3'd0); chk("R6 load bit copies reload", rdata, 32'd5);
    setaddr(3'd1); chk("R10 fresh prescaler period", rdata, 32'hFF);
    setaddr(3'd0);
    repeat (255) @(posedge clk);
    @(negedge clk);
    chk("R2 no step before period ends", rdata, 32'd5);
    @(negedge clk);
    chk("R2 step after scaler+1 cycles", rdata, 32'd4);
    n = 0;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      n += rtc_irq;
    end
    chk("R4 one-shot gives one interrupt", n, 32'd1);
    chk("R4 one-shot stops at zero", rdata, 32'd0);

    // GPT periodic: scaler 2, reload 3
    wr(3'd3, 32'd2);
    wr(3'd2, 32'd3);
    wr(3'd4, 32'h0000_0007);
    n = 0;
    for (int i = 0; i < 48; i++) begin
      @(negedge clk);
      n += gpt_irq;
    end
    chk("R4 periodic reload count", n, 32'd4);

    wr(3'd4, 32'h0000_0017);
    chk("R9 par_err on stray control bit", {31'd0, par_err}, 32'd1);

    // every-cycle underflow
    wr(3'd2, 32'd0);
    wr(3'd3, 32'd0);
    wr(3'd4, 32'h0000_000F);
    n = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      n += gpt_irq;
    end
    chk("R3 pulse per underflow", n, 32'd10);
    wr(3'd4, 32'h0000_0005);
    chk("R11 control write suppresses step", {31'd0, gpt_irq}, 32'd0);
    @(negedge clk);
    chk("R3 pulse resumes after control write", {31'd0, gpt_irq}, 32'd1);

    // stop
    wr(3'd2, 32'd9);
    wr(3'd4, 32'h0000_0002);
    setaddr(3'd2); hold = rdata;
    chk("R6 gpt load bit", hold, 32'd9);
    n = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      n += gpt_irq;
    end
    chk("R10 stopped timer silent", n, 32'd0);
    chk("R10 stopped counter held", rdata, hold);

    // GPT scaler width
    wr(3'd3, 32'h0001_2345);
    chk("R9 par_err on wide gpt scaler", {31'd0, par_err}, 32'd1);
    wr(3'd4, 32'h0000_000C);
    setaddr(3'd3); chk("R8 gpt scaler keeps 16 bits", rdata, 32'h2345);
    repeat (20) @(negedge clk);

    wr(3'd4, 32'd0);
    repeat (5) @(negedge clk);
    done = 1;
    summary();
    $finish;
  end
endmodule